// File: doc/BRIEF.md
# Exception Cause Recording and Vector Selection

This block is the part of a processor core that records machine state when an exception is raised and picks the vector to enter. It holds a small set of special registers:

- the processor-status exception-mode bit and user-mode bit;
- the primary exception PC;
- a separate double-exception PC;
- the cause code;
- the faulting virtual address.

A raise presents the faulting PC, a cause code and, if valid, a faulting address. One clock later the block pulses a vector-taken strobe with a vector code. The code is kernel, user or double. Double is chosen when the core was already handling an exception, that is, when exception mode was set at the time of the raise.

A misaligned-access strobe is also accepted. It turns into an alignment exception only when the core is configured to trap on unaligned accesses and has no hardware alignment handling. A register write port lets software load any of the registers and clear exception mode after a handler.

The control is a two-state machine, `exc_vec_fsm`, with these states and transitions:

- `ST_IDLE` means no vector is being taken this cycle.
- `ST_TAKE` means the vector strobe is high for this cycle.
- Transition *accept*: `ST_IDLE` goes to `ST_TAKE` on a qualified exception.
- Transition *retire*: `ST_TAKE` goes to `ST_IDLE` when no new exception arrives.
- Transition *chain*: `ST_TAKE` stays in `ST_TAKE` when back-to-back exceptions arrive.

Top module: `exc_dispatch`

## Requirements
- R1: A qualified exception taken while exception mode is 1 selects the double vector (code 2). Its PC goes to the double-exception PC register when `cfg_has_depc_i` is 1, leaving the primary PC unchanged. When `cfg_has_depc_i` is 0 its PC goes to the primary PC register, leaving the double-exception PC unchanged.
- R2: A qualified exception taken while exception mode is 0 saves its PC to the primary PC register and leaves the double-exception PC unchanged. It selects the user vector (code 1) when the user-mode bit is 1 and the kernel vector (code 0) when it is 0.
- R3: Every qualified exception writes its cause to the cause register and sets exception mode to 1. The user-mode bit is left unchanged.
- R4: A raise with `raise_vaddr_vld_i` = 1 writes `raise_vaddr_i` to the faulting-address register in the same update. With the flag at 0 that register is unchanged.
- R5: A `misalign_i` strobe without `raise_i` becomes an exception only when `cfg_unalign_trap_i` = 1 and `cfg_hw_align_i` = 0. Such an exception uses cause `ALIGN_CAUSE` (default 9), PC `raise_pc_i` and address `raise_vaddr_i`, which is always recorded. Otherwise the strobe has no effect on any output.
- R6: `vec_take_o` is high for exactly the one cycle after each clock edge that samples a qualified exception, and it is high in consecutive cycles for back-to-back exceptions. `vec_code_o` carries 0 kernel, 1 user or 2 double while the strobe is high, and reads 0 otherwise.
- R7: A software write (`sw_we_i`) with `sw_sel_i` selects its target as follows:
  - 0 is status: bit 0 sets exception mode and bit 1 sets user mode.
  - 1 is the primary PC.
  - 2 is the double-exception PC.
  - 3 is the cause, taken from the low 6 bits.
  - 4 is the faulting address.
  - 5 to 7 change nothing.
- R8: When a qualified exception and a software write fall in the same cycle, the exception update is applied and the software write is dropped entirely.
- R9: Reset sets exception mode to 1 and clears user mode, both PC registers, the cause, the faulting address and the vector strobe.
- R10: When `raise_i` and `misalign_i` are both high, the exception uses the `raise_i` cause and address-valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_i | input | 1 | Exception raise strobe |
| raise_pc_i | input | 32 | Faulting PC |
| raise_cause_i | input | 6 | Cause code for `raise_i` |
| raise_vaddr_i | input | 32 | Faulting virtual address |
| raise_vaddr_vld_i | input | 1 | Address valid for `raise_i` |
| misalign_i | input | 1 | Unaligned access detected |
| cfg_unalign_trap_i | input | 1 | Unaligned accesses trap |
| cfg_hw_align_i | input | 1 | Hardware handles unaligned accesses |
| cfg_has_depc_i | input | 1 | Separate double-exception PC present |
| sw_we_i | input | 1 | Software register write enable |
| sw_sel_i | input | 3 | Software write target |
| sw_wdata_i | input | 32 | Software write data |
| vec_take_o | output | 1 | One-cycle vector-taken strobe |
| vec_code_o | output | 2 | Vector code |
| excm_o | output | 1 | Exception-mode bit |
| um_o | output | 1 | User-mode bit |
| epc1_o | output | 32 | Primary exception PC |
| depc_o | output | 32 | Double-exception PC |
| exccause_o | output | 6 | Cause register |
| excvaddr_o | output | 32 | Faulting-address register |

## Verification
The bench targets nested exceptions under both settings of the double-PC option. A design that saved the PC in the wrong register would clobber the primary PC that the outer handler still needs. A design that skipped the double vector would re-enter the kernel handler with its state already lost.

It drives the misaligned strobe under all four configuration pairs, so a gate with an inverted term raises spurious alignment traps or swallows real ones. It places raises on the same cycles as software writes and as each other: a wrong priority lets a handler's clearing write erase a freshly recorded cause. It also runs back-to-back raises, which catch a vector strobe that fails to re-assert or that sticks high.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [1:0] {
        VEC_KERNEL = 2'd0,
        VEC_USER   = 2'd1,
        VEC_DOUBLE = 2'd2
    } vec_e;

    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] SEL_PS    = 3'd0;
    localparam logic [SEL_W-1:0] SEL_EPC1  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DEPC  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_CAUSE = 3'd3;
    localparam logic [SEL_W-1:0] SEL_VADDR = 3'd4;

    localparam int PS_EXCM_BIT = 0;
    localparam int PS_UM_BIT   = 1;
endpackage

// File: rtl/exc_raise_merge.sv
module exc_raise_merge #(
    parameter int XW = 32,
    parameter int CW = 6,
    parameter logic [CW-1:0] ALIGN_CAUSE = 6'd9
) (
    input  logic          raise_i,
    input  logic [CW-1:0] cause_i,
    input  logic          vvld_i,
    input  logic          misalign_i,
    input  logic          trap_en_i,
    input  logic          hw_align_i,
    output logic          fire_o,
    output logic [CW-1:0] cause_o,
    output logic          vvld_o
);
    logic align_fire;

    always_comb begin
        align_fire = misalign_i && trap_en_i && !hw_align_i;
        fire_o     = raise_i || align_fire;
        if (raise_i) begin
            cause_o = cause_i;
            vvld_o  = vvld_i;
        end else begin
            cause_o = ALIGN_CAUSE;
            vvld_o  = 1'b1;
        end
    end
endmodule

// File: rtl/exc_sreg_file.sv
module exc_sreg_file
    import exc_pkg::*;
#(
    parameter int XW = 32,
    parameter int CW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic [XW-1:0]    pc_i,
    input  logic [CW-1:0]    cause_i,
    input  logic [XW-1:0]    vaddr_i,
    input  logic             vvld_i,
    input  logic             has_depc_i,
    input  logic             sw_we_i,
    input  logic [SEL_W-1:0] sw_sel_i,
    input  logic [XW-1:0]    sw_wdata_i,
    output logic             excm_o,
    output logic             um_o,
    output logic [XW-1:0]    epc1_o,
    output logic [XW-1:0]    depc_o,
    output logic [CW-1:0]    cause_o,
    output logic [XW-1:0]    vaddr_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            excm_o  <= 1'b1;
            um_o    <= 1'b0;
            epc1_o  <= '0;
            depc_o  <= '0;
            cause_o <= '0;
            vaddr_o <= '0;
        end else if (fire_i) begin
            if (excm_o && has_depc_i) begin
                depc_o <= pc_i;
            end else begin
                epc1_o <= pc_i;
            end
            cause_o <= cause_i;
            excm_o  <= 1'b1;
            if (vvld_i) begin
                vaddr_o <= vaddr_i;
            end
        end else if (sw_we_i) begin
            unique case (sw_sel_i)
                SEL_PS: begin
                    excm_o <= sw_wdata_i[PS_EXCM_BIT];
                    um_o   <= sw_wdata_i[PS_UM_BIT];
                end
                SEL_EPC1:  epc1_o  <= sw_wdata_i;
                SEL_DEPC:  depc_o  <= sw_wdata_i;
                SEL_CAUSE: cause_o <= sw_wdata_i[CW-1:0];
                SEL_VADDR: vaddr_o <= sw_wdata_i;
                default: ;
            endcase
        end
    end

    AST_EXCM_ON_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> excm_o); // R3
    AST_CAUSE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> cause_o == $past(cause_i)); // R3
    AST_DEPC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i && !excm_o |=> $stable(depc_o)); // R2
    AST_SW_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i && sw_we_i && sw_sel_i == SEL_EPC1 && !(excm_o && has_depc_i)
        |=> epc1_o == $past(pc_i)); // R8
endmodule

// File: rtl/exc_vec_fsm.sv
module exc_vec_fsm
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic excm_i,
    input  logic um_i,
    output logic take_o,
    output vec_e code_o
);
    typedef enum logic {ST_IDLE, ST_TAKE} st_e;

    st_e  st_q, st_d;
    vec_e sel_d, sel_q;

    always_comb begin
        sel_d = excm_i ? VEC_DOUBLE : (um_i ? VEC_USER : VEC_KERNEL);
        unique case (st_q)
            ST_IDLE: st_d = fire_i ? ST_TAKE : ST_IDLE;
            ST_TAKE: st_d = fire_i ? ST_TAKE : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            sel_q <= VEC_KERNEL;
        end else begin
            st_q  <= st_d;
            sel_q <= fire_i ? sel_d : VEC_KERNEL;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE: begin
                take_o = 1'b0;
                code_o = VEC_KERNEL;
            end
            ST_TAKE: begin
                take_o = 1'b1;
                code_o = sel_q;
            end
            default: begin
                take_o = 1'b0;
                code_o = VEC_KERNEL;
            end
        endcase
    end

    AST_TAKE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(fire_i)); // R6
    AST_FIRE_GIVES_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> take_o); // R6
    AST_NESTED_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i && excm_i |=> code_o == VEC_DOUBLE); // R1
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
    import exc_pkg::*;
#(
    parameter int XW = 32,
    parameter int CW = 6,
    parameter logic [CW-1:0] ALIGN_CAUSE = 6'd9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raise_i,
    input  logic [XW-1:0] raise_pc_i,
    input  logic [CW-1:0] raise_cause_i,
    input  logic [XW-1:0] raise_vaddr_i,
    input  logic          raise_vaddr_vld_i,
    input  logic          misalign_i,
    input  logic          cfg_unalign_trap_i,
    input  logic          cfg_hw_align_i,
    input  logic          cfg_has_depc_i,
    input  logic          sw_we_i,
    input  logic [2:0]    sw_sel_i,
    input  logic [XW-1:0] sw_wdata_i,
    output logic          vec_take_o,
    output logic [1:0]    vec_code_o,
    output logic          excm_o,
    output logic          um_o,
    output logic [XW-1:0] epc1_o,
    output logic [XW-1:0] depc_o,
    output logic [CW-1:0] exccause_o,
    output logic [XW-1:0] excvaddr_o
);
    logic          fire;
    logic [CW-1:0] f_cause;
    logic          f_vvld;
    vec_e          code;

    exc_raise_merge #(.XW(XW), .CW(CW), .ALIGN_CAUSE(ALIGN_CAUSE)) u_merge (
        .raise_i    (raise_i),
        .cause_i    (raise_cause_i),
        .vvld_i     (raise_vaddr_vld_i),
        .misalign_i (misalign_i),
        .trap_en_i  (cfg_unalign_trap_i),
        .hw_align_i (cfg_hw_align_i),
        .fire_o     (fire),
        .cause_o    (f_cause),
        .vvld_o     (f_vvld)
    );

    exc_sreg_file #(.XW(XW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (fire),
        .pc_i       (raise_pc_i),
        .cause_i    (f_cause),
        .vaddr_i    (raise_vaddr_i),
        .vvld_i     (f_vvld),
        .has_depc_i (cfg_has_depc_i),
        .sw_we_i    (sw_we_i),
        .sw_sel_i   (sw_sel_i),
        .sw_wdata_i (sw_wdata_i),
        .excm_o     (excm_o),
        .um_o       (um_o),
        .epc1_o     (epc1_o),
        .depc_o     (depc_o),
        .cause_o    (exccause_o),
        .vaddr_o    (excvaddr_o)
    );

    exc_vec_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .excm_i (excm_o),
        .um_i   (um_o),
        .take_o (vec_take_o),
        .code_o (code)
    );

    assign vec_code_o = code;

    AST_ALIGN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_i && !raise_i && (!cfg_unalign_trap_i || cfg_hw_align_i)
        |=> !vec_take_o); // R5
    AST_VADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        raise_i && raise_vaddr_vld_i |=> excvaddr_o == $past(raise_vaddr_i)); // R4
    AST_USER_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        raise_i && !excm_o && um_o |=> vec_code_o == 2'd1); // R2
endmodule

// File: tb/test_exc_dispatch.sv
module test_exc_dispatch;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raise_i = 0, raise_vaddr_vld_i = 0, misalign_i = 0;
    logic        cfg_unalign_trap_i = 0, cfg_hw_align_i = 0, cfg_has_depc_i = 0;
    logic        sw_we_i = 0;
    logic [2:0]  sw_sel_i = 0;
    logic [31:0] raise_pc_i = 0, raise_vaddr_i = 0, sw_wdata_i = 0;
    logic [5:0]  raise_cause_i = 0;
    logic        vec_take_o, excm_o, um_o;
    logic [1:0]  vec_code_o;
    logic [31:0] epc1_o, depc_o, excvaddr_o;
    logic [5:0]  exccause_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    bit          m_take = 0, m_excm = 1, m_um = 0;
    int          m_code = 0;
    logic [31:0] m_epc1 = 0, m_depc = 0, m_va = 0;
    logic [5:0]  m_cause = 0;

    exc_dispatch i_exc_dispatch (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        bit fire;
        logic [5:0] c;
        bit vv;
        if (!rst_n) begin
            m_take = 0; m_code = 0; m_excm = 1; m_um = 0;
            m_epc1 = 0; m_depc = 0; m_va = 0; m_cause = 0;
        end else begin
            fire = raise_i || (misalign_i && cfg_unalign_trap_i && !cfg_hw_align_i);
            c  = raise_i ? raise_cause_i : 6'd9;
            vv = raise_i ? raise_vaddr_vld_i : 1'b1;
            if (fire) begin
                m_take = 1;
                if (m_excm) begin
                    m_code = 2;
                    if (cfg_has_depc_i) m_depc = raise_pc_i;
                    else m_epc1 = raise_pc_i;
                end else begin
                    m_code = m_um ? 1 : 0;
                    m_epc1 = raise_pc_i;
                end
                m_cause = c;
                m_excm = 1;
                if (vv) m_va = raise_vaddr_i;
            end else begin
                m_take = 0;
                m_code = 0;
                if (sw_we_i) begin
                    case (sw_sel_i)
                        3'd0: begin m_excm = sw_wdata_i[0]; m_um = sw_wdata_i[1]; end
                        3'd1: m_epc1 = sw_wdata_i;
                        3'd2: m_depc = sw_wdata_i;
                        3'd3: m_cause = sw_wdata_i[5:0];
                        3'd4: m_va = sw_wdata_i;
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // compare every cycle away from the clock edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 vec_take", {31'd0, vec_take_o}, {31'd0, m_take});
            chk("R6 vec_code", {30'd0, vec_code_o}, m_code);
            chk("R3 excm", {31'd0, excm_o}, {31'd0, m_excm});
            chk("R7 um", {31'd0, um_o}, {31'd0, m_um});
            chk("R2 epc1", epc1_o, m_epc1);
            chk("R1 depc", depc_o, m_depc);
            chk("R3 exccause", {26'd0, exccause_o}, {26'd0, m_cause});
            chk("R4 excvaddr", excvaddr_o, m_va);
        end
    end

    task automatic idle();
        raise_i = 0; misalign_i = 0; sw_we_i = 0; raise_vaddr_vld_i = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic raise(logic [31:0] pc, logic [5:0] c, logic vv, logic [31:0] va);
        raise_i = 1; raise_pc_i = pc; raise_cause_i = c;
        raise_vaddr_vld_i = vv; raise_vaddr_i = va;
    endtask

    task automatic swr(logic [2:0] s, logic [31:0] d);
        sw_we_i = 1; sw_sel_i = s; sw_wdata_i = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values while reset is held
        chk("R9 excm reset", {31'd0, excm_o}, 32'd1);
        chk("R9 take reset", {31'd0, vec_take_o}, 32'd0);
        chk("R9 epc1 reset", epc1_o, 32'd0);
        chk("R9 cause reset", {26'd0, exccause_o}, 32'd0);
        rst_n = 1;
        step();
        // R2: kernel entry after clearing EXCM
        swr(3'd0, 32'h0); step(); idle();
        raise(32'h100, 6'd3, 1, 32'hdead0000); step(); idle(); step();
        chk("R2 kernel code", {31'd0, vec_take_o}, 32'd0);
        // R1: nested without DEPC option
        cfg_has_depc_i = 0;
        raise(32'h200, 6'd5, 0, 32'h0); step(); idle(); step();
        // R1: nested with DEPC option
        cfg_has_depc_i = 1;
        raise(32'h300, 6'd7, 1, 32'h1234); step(); idle(); step();
        // R2: user vector
        swr(3'd0, 32'h2); step(); idle();
        raise(32'h400, 6'd1, 0, 32'hffff); step(); idle(); step();
        // R5: all four config pairs, R10 priority
        for (int k = 0; k < 4; k++) begin
            cfg_unalign_trap_i = k[0]; cfg_hw_align_i = k[1];
            swr(3'd0, 32'h0); step(); idle();
            misalign_i = 1; raise_pc_i = 32'h500 + k; raise_vaddr_i = 32'h77 + k;
            step(); idle(); step();
        end
        cfg_unalign_trap_i = 1; cfg_hw_align_i = 0;
        raise(32'h600, 6'd2, 0, 32'h88); misalign_i = 1; step(); idle(); step(); // R10
        // R8: simultaneous raise and software write
        raise(32'h700, 6'd4, 0, 0); swr(3'd3, 32'h3f); step(); idle(); step();
        raise(32'h710, 6'd4, 0, 0); swr(3'd0, 32'h0); step(); idle(); step();
        // R6: back-to-back raises
        raise(32'h800, 6'd8, 0, 0); step(); raise(32'h804, 6'd9, 0, 0); step();
        idle(); step(); step();
        // R7: every write target, including ignored selectors
        for (int s = 0; s < 8; s++) begin
            swr(s[2:0], 32'hA5A5_0000 + s); step(); idle(); step();
        end
        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            raise_i = ($urandom % 4) == 0;
            misalign_i = ($urandom % 5) == 0;
            raise_pc_i = $urandom; raise_vaddr_i = $urandom;
            raise_cause_i = 6'($urandom); raise_vaddr_vld_i = 1'($urandom);
            cfg_unalign_trap_i = 1'($urandom); cfg_hw_align_i = 1'($urandom);
            cfg_has_depc_i = 1'($urandom);
            sw_we_i = ($urandom % 3) == 0;
            sw_sel_i = 3'($urandom); sw_wdata_i = $urandom;
            step();
        end
        idle(); step(); step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule